// File: doc/BRIEF.md
# Single-Channel Word-Copy DMA Engine

This block moves a run of data words without processor involvement. Software first sets up the job through a small register port. It gives a source start address, a destination start address, an address-stepping mode for each side, a word count and a control word. The engine then waits until a peripheral raises its service request. It answers with a one-cycle acknowledge and then copies words one at a time. Each word is fetched from the current source address over a master bus port into an internal holding register, and is then written out to the current destination address.

After each word, each address moves up by one, moves down by one or stays put. A fixed peripheral data port can therefore fill an incrementing memory buffer, and two memory regions can be copied in either direction. The job ends in one of two ways. In length mode it ends when the count of written words equals the programmed length. In peripheral mode, used when the length is not known in advance, it ends on the word during whose read the peripheral holds its end-of-data line high. At the end a sticky done flag is set, which drives the interrupt output, and the engine goes back to waiting for a request.

Top module: `dma_one_chan`

## Requirements
- R1: After reset, irq, dack and m_valid are low, and every register reads zero.
- R2: The register offsets are: 0 source start, 1 destination start, 2 length, 3 modes (bits 1:0 source, bits 3:2 destination), 4 control (bit 0 enable, bit 1 peripheral-end termination), 5 status (bit 0 done, bit 1 busy). Writable fields read back what was written.
- R3: While enable is 0, a high dreq causes no dack and no bus request.
- R4: With enable set, dack is high for exactly the one cycle that follows the clock edge at which dreq is sampled high in idle. The first bus read is presented in the cycle after that.
- R5: Each word is read from the source address (m_write=0) and then written unchanged to the destination address (m_write=1). m_valid, m_write, m_addr and m_wdata stay stable until m_ready is seen.
- R6: Address mode encoding: 00 fixed, 01 increment, 10 decrement (11 behaves as fixed). Each address steps by one after every written word.
- R7: In length mode (control bit 1 = 0), exactly LEN words are moved, and dend is ignored.
- R8: In peripheral mode (control bit 1 = 1), dend is sampled at the read handshake. The word read with dend high is the last one written, and LEN is ignored.
- R9: Status bit 0 (done) and irq go high on the clock edge that accepts the final write, and the engine returns to idle.
- R10: Writing status with bit 0 = 1 clears done and drops irq. Writing bit 0 = 0 leaves it set.
- R11: Register writes are ignored while a job is active.
- R12: A zero length in length mode completes two edges after the request, with no bus activity.
- R13: Status bit 1 (busy) reads 1 from the acknowledge until completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | CFG_AW | Register offset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Register read data (combinational) |
| dreq | input | 1 | Peripheral service request |
| dend | input | 1 | Peripheral end-of-data marker |
| dack | output | 1 | One-cycle acknowledge of the request |
| m_valid | output | 1 | Master bus request valid |
| m_write | output | 1 | Master bus direction, 1 = write |
| m_addr | output | DW | Master bus word address |
| m_wdata | output | DW | Master bus write data |
| m_rdata | input | DW | Master bus read data |
| m_ready | input | 1 | Master bus completion |
| irq | output | 1 | Interrupt request (mirrors done) |

## Verification
The acknowledge is due one sampled edge after dreq. The first read is due one edge later, and the zero-length completion two edges after the request. These outputs are sampled 1 ns after the corresponding edges. Completion is checked by cycle stamping: the edge index of the final accepted write is logged, and irq must read high just after that same edge. The data and address order is compared word by word from a log of bus handshakes, and the logged sequence is independent of the memory latency the bench inserts.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    AM_FIXED = 2'b00,
    AM_INC   = 2'b01,
    AM_DEC   = 2'b10,
    AM_RSVD  = 2'b11
  } amode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACK,
    ST_RD,
    ST_WR
  } st_e;

  localparam int OFS_SRC  = 0;
  localparam int OFS_DST  = 1;
  localparam int OFS_LEN  = 2;
  localparam int OFS_MODE = 3;
  localparam int OFS_CTRL = 4;
  localparam int OFS_STAT = 5;
endpackage

// File: rtl/dma_addr_unit.sv
module dma_addr_unit
  import dma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] start,
  input  logic          adv,
  input  amode_e        mode,
  output logic [AW-1:0] cur
);
  function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a, input amode_e m);
    case (m)
      AM_INC:  return a + AW'(1);
      AM_DEC:  return a - AW'(1);
      default: return a;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cur <= '0;
    else if (load) cur <= start;
    else if (adv)  cur <= next_addr(cur, mode);
  end

  assert_step_inc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !load && mode == AM_INC |=> cur == $past(cur) + AW'(1));
  assert_step_dec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !load && mode == AM_DEC |=> cur == $past(cur) - AW'(1));
  assert_step_fix_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !load && (mode == AM_FIXED || mode == AM_RSVD) |=> $stable(cur));
endmodule

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int DW     = 32,
  parameter int CFG_AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic              cfg_we,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [DW-1:0]     cfg_rdata,
  input  logic              busy,
  input  logic              done_set,
  output logic [DW-1:0]     src_start,
  output logic [DW-1:0]     dst_start,
  output logic [DW-1:0]     len,
  output amode_e            src_mode,
  output amode_e            dst_mode,
  output logic              enable,
  output logic              term_periph,
  output logic              done
);
  logic wr_ok;
  assign wr_ok = cfg_we && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_start   <= '0;
      dst_start   <= '0;
      len         <= '0;
      src_mode    <= AM_FIXED;
      dst_mode    <= AM_FIXED;
      enable      <= 1'b0;
      term_periph <= 1'b0;
    end else if (wr_ok) begin
      case (cfg_addr)
        CFG_AW'(OFS_SRC): src_start <= cfg_wdata;
        CFG_AW'(OFS_DST): dst_start <= cfg_wdata;
        CFG_AW'(OFS_LEN): len       <= cfg_wdata;
        CFG_AW'(OFS_MODE): begin
          src_mode <= amode_e'(cfg_wdata[1:0]);
          dst_mode <= amode_e'(cfg_wdata[3:2]);
        end
        CFG_AW'(OFS_CTRL): begin
          enable      <= cfg_wdata[0];
          term_periph <= cfg_wdata[1];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        done <= 1'b0;
    else if (done_set) done <= 1'b1;
    else if (wr_ok && cfg_addr == CFG_AW'(OFS_STAT) && cfg_wdata[0]) done <= 1'b0;
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      CFG_AW'(OFS_SRC):  cfg_rdata = src_start;
      CFG_AW'(OFS_DST):  cfg_rdata = dst_start;
      CFG_AW'(OFS_LEN):  cfg_rdata = len;
      CFG_AW'(OFS_MODE): cfg_rdata = {{(DW-4){1'b0}}, dst_mode, src_mode};
      CFG_AW'(OFS_CTRL): cfg_rdata = {{(DW-2){1'b0}}, term_periph, enable};
      CFG_AW'(OFS_STAT): cfg_rdata = {{(DW-2){1'b0}}, busy, done};
      default:           cfg_rdata = '0;
    endcase
  end

  assert_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cfg_we |=> $stable(src_start) && $stable(dst_start) && $stable(len)
                       && $stable(src_mode) && $stable(dst_mode));
  assert_done_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_set |=> done);
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          term_periph,
  input  logic [DW-1:0] len,
  input  logic          dreq,
  input  logic          dend,
  input  logic          m_ready,
  input  logic [DW-1:0] m_rdata,
  input  logic [DW-1:0] src_cur,
  input  logic [DW-1:0] dst_cur,
  output logic          dack,
  output logic          load_addr,
  output logic          adv,
  output logic          done_set,
  output logic          busy,
  output logic          m_valid,
  output logic          m_write,
  output logic [DW-1:0] m_addr,
  output logic [DW-1:0] m_wdata
);
  st_e           st;
  logic [DW-1:0] cnt;
  logic [DW-1:0] hold;
  logic          last_q;

  function automatic logic len_reached(input logic [DW-1:0] c, input logic [DW-1:0] l);
    return ({1'b0, c} + (DW+1)'(1)) == {1'b0, l};
  endfunction

  logic start_evt, rd_fire, wr_fire, zero_len, item_last, fin_evt;
  assign start_evt = (st == ST_IDLE) && enable && dreq;
  assign rd_fire   = (st == ST_RD) && m_ready;
  assign wr_fire   = (st == ST_WR) && m_ready;
  assign zero_len  = (st == ST_ACK) && !term_periph && (len == '0);
  assign item_last = term_periph ? last_q : len_reached(cnt, len);
  assign fin_evt   = (wr_fire && item_last) || zero_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      hold   <= '0;
      last_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start_evt) begin
          st  <= ST_ACK;
          cnt <= '0;
        end
        ST_ACK: st <= zero_len ? ST_IDLE : ST_RD;
        ST_RD: if (rd_fire) begin
          hold   <= m_rdata;
          last_q <= dend;
          st     <= ST_WR;
        end
        ST_WR: if (wr_fire) begin
          cnt <= cnt + DW'(1);
          st  <= item_last ? ST_IDLE : ST_RD;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign load_addr = start_evt;
  assign adv       = wr_fire;
  assign done_set  = fin_evt;
  assign busy      = (st != ST_IDLE);
  assign dack      = (st == ST_ACK);
  assign m_valid   = (st == ST_RD) || (st == ST_WR);
  assign m_write   = (st == ST_WR);
  assign m_addr    = (st == ST_WR) ? dst_cur : src_cur;
  assign m_wdata   = hold;

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_addr) && $stable(m_write) && $stable(m_wdata));
  assert_ack_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dack |=> !dack);
  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !m_valid && !dack);
  assert_read_then_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> m_valid && m_write && m_wdata == $past(m_rdata));
  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !term_periph |-> cnt <= len);
  assert_len_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire && !term_periph && len_reached(cnt, len) |=> !busy);
  assert_periph_cont_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire && term_periph && !last_q |=> m_valid && !m_write);
  assert_zero_len_R12: assert property (@(posedge clk) disable iff (!rst_n)
    dack && !term_periph && len == '0 |=> !busy && !m_valid);
endmodule

// File: rtl/dma_one_chan.sv
module dma_one_chan
  import dma_pkg::*;
#(
  parameter int DW     = 32,
  parameter int CFG_AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic              cfg_we,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [DW-1:0]     cfg_rdata,
  input  logic              dreq,
  input  logic              dend,
  output logic              dack,
  output logic              m_valid,
  output logic              m_write,
  output logic [DW-1:0]     m_addr,
  output logic [DW-1:0]     m_wdata,
  input  logic [DW-1:0]     m_rdata,
  input  logic              m_ready,
  output logic              irq
);
  localparam int NSIDE = 2;

  logic [DW-1:0] src_start, dst_start, len;
  amode_e        src_mode, dst_mode;
  logic          enable, term_periph, done;
  logic          busy, done_set, load_addr, adv;
  logic [DW-1:0] a_start [NSIDE];
  logic [DW-1:0] a_cur   [NSIDE];
  amode_e        a_mode  [NSIDE];

  dma_regs #(.DW(DW), .CFG_AW(CFG_AW)) u_regs (
    .clk, .rst_n, .cfg_addr, .cfg_we, .cfg_wdata, .cfg_rdata,
    .busy, .done_set, .src_start, .dst_start, .len,
    .src_mode, .dst_mode, .enable, .term_periph, .done
  );

  assign a_start[0] = src_start;
  assign a_start[1] = dst_start;
  assign a_mode[0]  = src_mode;
  assign a_mode[1]  = dst_mode;

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    dma_addr_unit #(.AW(DW)) u_au (
      .clk, .rst_n, .load(load_addr), .start(a_start[g]),
      .adv, .mode(a_mode[g]), .cur(a_cur[g])
    );
  end

  dma_engine #(.DW(DW)) u_eng (
    .clk, .rst_n, .enable, .term_periph, .len, .dreq, .dend,
    .m_ready, .m_rdata, .src_cur(a_cur[0]), .dst_cur(a_cur[1]),
    .dack, .load_addr, .adv, .done_set, .busy,
    .m_valid, .m_write, .m_addr, .m_wdata
  );

  assign irq = done;

  assert_irq_rst_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(busy));
endmodule

// File: tb/dma_one_chan_tb.sv
module dma_one_chan_tb;
  localparam int DW = 32;
  localparam logic [31:0] PERIPH = 32'h0000_00F0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic          cfg_we = 1'b0;
  logic [DW-1:0] cfg_wdata = '0, cfg_rdata;
  logic dreq = 1'b0, dend, dack, m_valid, m_write, m_ready, irq;
  logic [DW-1:0] m_addr, m_wdata, m_rdata;

  int errors = 0, checks = 0;
  int lat = 0, wait_cnt = 0, pcnt = 0, end_at = 1000, cyc = 0, last_wr_cyc = 0;
  int rd_n = 0, wr_n = 0;
  logic dend_force = 1'b0;
  logic [31:0] mem [0:255];
  logic [31:0] wr_addr [0:31];
  logic [31:0] wr_data [0:31];

  always #5 clk = ~clk;

  dma_one_chan #(.DW(DW), .CFG_AW(3)) u_dut (
    .clk, .rst_n, .cfg_addr, .cfg_we, .cfg_wdata, .cfg_rdata,
    .dreq, .dend, .dack, .m_valid, .m_write, .m_addr, .m_wdata,
    .m_rdata, .m_ready, .irq
  );

  function automatic logic [31:0] init_val(input int a);
    return 32'hA500_0000 | 32'(a);
  endfunction

  assign m_ready = m_valid && (wait_cnt >= lat);
  assign m_rdata = (m_addr == PERIPH) ? 32'hC0DE_0000 + 32'(pcnt) : mem[m_addr[7:0]];
  assign dend = dend_force || (m_valid && !m_write && m_addr == PERIPH && pcnt == end_at);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (m_valid && m_ready) begin
      wait_cnt <= 0;
      if (m_write) begin
        mem[m_addr[7:0]] <= m_wdata;
        if (wr_n < 32) begin
          wr_addr[wr_n] <= m_addr;
          wr_data[wr_n] <= m_wdata;
        end
        wr_n <= wr_n + 1;
        last_wr_cyc <= cyc;
      end else begin
        rd_n <= rd_n + 1;
        if (m_addr == PERIPH) pcnt <= pcnt + 1;
      end
    end else if (m_valid) wait_cnt <= wait_cnt + 1;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_addr = 3'(a); cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input int a, output logic [31:0] d);
    cfg_addr = 3'(a);
    #1;
    d = cfg_rdata;
  endtask

  task automatic setup(input logic [31:0] s, input logic [31:0] d, input logic [31:0] n,
                       input logic [3:0] modes, input logic [1:0] ctrl);
    cfg_write(5, 32'h1);
    cfg_write(0, s); cfg_write(1, d); cfg_write(2, n);
    cfg_write(3, {28'h0, modes}); cfg_write(4, {30'h0, ctrl});
    wr_n = 0; rd_n = 0; pcnt = 0;
  endtask

  task automatic launch(input logic expect_bus);
    @(negedge clk); dreq = 1'b1;
    @(posedge clk); #1;
    chk("R4", "dack after request", 32'(dack), 1);
    chk("R4", "no bus during ack", 32'(m_valid), 0);
    dreq = 1'b0;
    @(posedge clk); #1;
    chk("R4", "dack one cycle", 32'(dack), 0);
    chk(expect_bus ? "R4" : "R12", "bus after ack", 32'(m_valid && !m_write), 32'(expect_bus));
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq && n < 500) begin
      @(posedge clk); #1; n++;
    end
    chk(req, "irq reached", 32'(irq), 1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1", "irq", 32'(irq), 0);
    chk("R1", "dack", 32'(dack), 0);
    chk("R1", "m_valid", 32'(m_valid), 0);
    for (int i = 0; i < 6; i++) begin
      cfg_read(i, d);
      chk("R1", "reg reset", d, 0);
    end
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    cfg_write(0, 32'h1234_5678); cfg_write(1, 32'h0BAD_F00D);
    cfg_write(2, 32'd77); cfg_write(3, 32'h9); cfg_write(4, 32'h2);
    cfg_read(0, d); chk("R2", "src", d, 32'h1234_5678);
    cfg_read(1, d); chk("R2", "dst", d, 32'h0BAD_F00D);
    cfg_read(2, d); chk("R2", "len", d, 32'd77);
    cfg_read(3, d); chk("R2", "modes", d, 32'h9);
    cfg_read(4, d); chk("R2", "ctrl", d, 32'h2);
  endtask

  task automatic t_disabled();
    int seen = 0;
    cfg_write(4, 32'h0);
    @(negedge clk); dreq = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); #1;
      if (dack || m_valid) seen++;
    end
    dreq = 1'b0;
    chk("R3", "activity while disabled", 32'(seen), 0);
  endtask

  task automatic t_inc_len();
    logic [31:0] d;
    lat = 0;
    setup(32'h10, 32'h80, 32'd4, 4'b0101, 2'b01);
    launch(1'b1);
    cfg_read(5, d); chk("R13", "busy bit", d & 32'h2, 32'h2);
    wait_irq("R9");
    chk("R9", "irq on final write edge", 32'(cyc), 32'(last_wr_cyc + 1));
    chk("R7", "word count", 32'(wr_n), 4);
    chk("R7", "read count", 32'(rd_n), 4);
    for (int i = 0; i < 4; i++) begin
      chk("R6", "inc dst addr", wr_addr[i], 32'h80 + 32'(i));
      chk("R5", "copied data", wr_data[i], init_val(16 + i));
    end
    cfg_read(5, d); chk("R13", "idle after done", d, 32'h1);
  endtask

  task automatic t_periph();
    lat = 2; end_at = 4;
    setup(PERIPH, 32'h40, 32'd2, 4'b0100, 2'b11);
    launch(1'b1);
    wait_irq("R8");
    chk("R8", "words until end marker", 32'(wr_n), 5);
    for (int i = 0; i < 5; i++) begin
      chk("R6", "fixed src / inc dst", wr_addr[i], 32'h40 + 32'(i));
      chk("R5", "periph data", wr_data[i], 32'hC0DE_0000 + 32'(i));
    end
    end_at = 1000;
  endtask

  task automatic t_dec_locked();
    logic [31:0] d;
    lat = 1; dend_force = 1'b1;
    setup(32'h30, 32'h70, 32'd3, 4'b1010, 2'b01);
    launch(1'b1);
    cfg_write(0, 32'h99);
    cfg_write(2, 32'd9);
    wait_irq("R7");
    dend_force = 1'b0;
    chk("R7", "dend ignored in length mode", 32'(wr_n), 3);
    for (int i = 0; i < 3; i++) begin
      chk("R6", "dec dst addr", wr_addr[i], 32'h70 - 32'(i));
      chk("R6", "dec src data", wr_data[i], init_val(48 - i));
    end
    cfg_read(0, d); chk("R11", "src unchanged", d, 32'h30);
    cfg_read(2, d); chk("R11", "len unchanged", d, 32'd3);
  endtask

  task automatic t_w1c();
    cfg_write(5, 32'h0);
    #1; chk("R10", "write 0 keeps irq", 32'(irq), 1);
    cfg_write(5, 32'h1);
    #1; chk("R10", "write 1 clears irq", 32'(irq), 0);
  endtask

  task automatic t_zero();
    lat = 0;
    setup(32'h10, 32'h90, 32'd0, 4'b0101, 2'b01);
    launch(1'b0);
    chk("R12", "irq two edges after request", 32'(irq), 1);
    repeat (3) @(posedge clk);
    #1;
    chk("R12", "no reads", 32'(rd_n), 0);
    chk("R12", "no writes", 32'(wr_n), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = init_val(i);
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_regmap();
    t_disabled();
    t_inc_len();
    t_periph();
    t_dec_locked();
    t_w1c();
    t_zero();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule